// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block watches eight asynchronous external interrupt request lines and turns each into an internal request bit. Each line has its own sense mode: active-low level, falling edge, rising edge, or both edges. The modes live in one 16-bit control register, and a small register bus reads and writes it.

Each line is brought into the clock domain by a two-stage synchroniser. A further sample register holds the previous synchronised value, which is used for edge detection. In the three edge modes, a detected transition sets a sticky pending flag. Software then clears that flag through a per-line clear strobe. In level mode the request bit simply mirrors the inverted synchronised input.

An interrupt controller downstream consumes the 8-bit request vector. Masking, priority and vectoring are left to that controller.

Top module: `irq_sense_top`

## Requirements
- R1: After reset the control register reads 16'h0000, every line is in level mode, and with all inputs held high the request vector is 8'h00.
- R2: A write strobe loads the full 16-bit control register on the next clock edge, and the read port returns the stored value. Line n uses bits [2n+1:2n]. A field value of 2'b00 selects level, 2'b01 falling edge, 2'b10 rising edge and 2'b11 both edges.
- R3: In level mode the request bit equals the inverted input, delayed by two clock edges. It is not latched: it drops again when the input returns high.
- R4: In falling-edge mode, a high-to-low input change sets the request bit at the third clock edge after the change. A low-to-high change sets nothing.
- R5: In rising-edge mode, a low-to-high input change sets the request bit. A high-to-low change sets nothing.
- R6: In both-edges mode, either input transition sets the request bit.
- R7: In an edge mode, the request bit stays set after the input settles, until a clear strobe for that line arrives. In level mode a clear strobe has no effect on the request bit.
- R8: If a new edge and a clear strobe for the same line fall in the same cycle, the request bit stays set.
- R9: A write that changes a line's mode field clears that line's pending request. The mode change alone does not produce a request.
- R10: Lines are independent: different modes on different lines yield each line's own result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Raw external request lines, asynchronous |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control register write data |
| rd_data_o | output | 16 | Control register read data |
| clr_i | input | 8 | Per-line clear strobe for pending edge requests |
| req_o | output | 8 | Request vector, one bit per line |

## Verification
The assertions assume that clear strobes and mode writes are synchronous to the clock. They also assume that a mode write counts as a change only when a field's value actually differs. The edge-related properties reason on the synchronised samples, so they make no assumption about when the raw lines move. The stimulus drives every input on the falling clock edge. It lets each input level settle for several cycles before it writes a mode or pulses a clear. In this way every observed request traces back to exactly one intended transition.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned CTRL_W  = NUM_IRQ * MODE_W;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_mode_e;
endpackage

// File: rtl/irq_sync_pipe.sv
module irq_sync_pipe #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned N = NUM_IRQ,
  localparam int unsigned W = N * MODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] mode_o,
  output logic [N-1:0] mode_chg_o
);
  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i;
  end

  // a field counts as changed only if its value differs
  for (genvar n = 0; n < N; n++) begin : g_chg
    assign mode_chg_o[n] = wr_en_i &&
      (wr_data_i[n*MODE_W +: MODE_W] != ctrl_q[n*MODE_W +: MODE_W]);
  end

  assign mode_o = ctrl_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mode_o == $past(wr_data_i))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mode_o)); // R2
endmodule

// File: rtl/irq_sense_lane.sv
module irq_sense_lane
  import irq_sense_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sync_i,
  input  sense_mode_e mode_i,
  input  logic        mode_chg_i,
  input  logic        clr_i,
  output logic        req_o
);
  logic prev_q, pend_q, pend_d;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_i;
  end

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // mode change wins, then a fresh edge, then clear
  always_comb begin
    if (mode_chg_i)  pend_d = 1'b0;
    else if (hit)    pend_d = 1'b1;
    else if (clr_i)  pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign req_o = (mode_i == SENSE_LOW) ? ~sync_i : pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && pend_q && !clr_i && !mode_chg_i) |=> pend_q); // R7
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RISE && sync_i && !prev_q && !mode_chg_i) |=> pend_q); // R5
  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && !sync_i && prev_q && !mode_chg_i) |=> pend_q); // R4
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_BOTH && (sync_i != prev_q) && clr_i && !mode_chg_i) |=> pend_q); // R8
  AST_MODE_CHG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> !pend_q); // R9
  AST_LOW_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW) |-> !pend_q); // R3
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
  import irq_sense_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQ-1:0]  irq_i,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  output logic [CTRL_W-1:0]   rd_data_o,
  input  logic [NUM_IRQ-1:0]  clr_i,
  output logic [NUM_IRQ-1:0]  req_o
);
  logic [NUM_IRQ-1:0] irq_sync, mode_chg;
  logic [CTRL_W-1:0]  mode;

  irq_sync_pipe #(.W(NUM_IRQ), .RST_VAL({NUM_IRQ{1'b1}})) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .sync_o  (irq_sync)
  );

  irq_mode_regs #(.N(NUM_IRQ)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .mode_chg_o (mode_chg)
  );

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_lane
    irq_sense_lane u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (irq_sync[n]),
      .mode_i     (sense_mode_e'(mode[n*MODE_W +: MODE_W])),
      .mode_chg_i (mode_chg[n]),
      .clr_i      (clr_i[n]),
      .req_o      (req_o[n])
    );
  end

  assign rd_data_o = mode;

  AST_RESET_READ: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (rd_data_o == '0)); // R1
endmodule

// File: tb/sim_irq_sense_top.sv
module sim_irq_sense_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq = 8'hFF;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  clr = '0;
  logic [7:0]  req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  irq_sense_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .clr_i(clr), .req_o(req)
  );

  // {mode, start level, end level, expected req}
  localparam logic [39:0] VEC [11] = '{
    {16'h0000, 8'hFF, 8'h00, 8'hFF},
    {16'h0000, 8'h00, 8'hFF, 8'h00},
    {16'h5555, 8'hFF, 8'h00, 8'hFF},
    {16'h5555, 8'h00, 8'hFF, 8'h00},
    {16'hAAAA, 8'h00, 8'hFF, 8'hFF},
    {16'hAAAA, 8'hFF, 8'h00, 8'h00},
    {16'hFFFF, 8'hFF, 8'h00, 8'hFF},
    {16'hFFFF, 8'h00, 8'hFF, 8'hFF},
    {16'hE4E4, 8'hFF, 8'h00, 8'hBB},
    {16'hE4E4, 8'h00, 8'hFF, 8'hCC},
    {16'h5555, 8'h0F, 8'hF0, 8'h0F}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input logic [7:0] m);
    clr = m;
    tick(1);
    clr = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    check("R1 ctrl", rd_data, 16'h0000);
    check("R1 req", {8'h00, req}, 16'h0000);

    write_mode(16'hA5C3);
    check("R2 readback", rd_data, 16'hA5C3);
    write_mode(16'h0000);
    check("R2 readback zero", rd_data, 16'h0000);

    for (int i = 0; i < 11; i++) begin
      logic [15:0] m;
      string tag;
      m = VEC[i][39:24];
      tag = (m == 16'h0000) ? "R3 table" : (m == 16'h5555) ? "R4 table" :
            (m == 16'hAAAA) ? "R5 table" : (m == 16'hFFFF) ? "R6 table" : "R10 table";
      irq = VEC[i][23:16];
      tick(4);
      write_mode(m);
      pulse_clr(8'hFF);
      tick(4);
      irq = VEC[i][15:8];
      tick(5);
      check(tag, {8'h00, req}, {8'h00, VEC[i][7:0]});
    end

    // pin0 level, pin1 fall, pin2 rise, pin3 both
    irq = 8'hFB;
    tick(4);
    write_mode(16'h00E4);
    tick(4);
    pulse_clr(8'hFF);
    tick(2);
    check("R10 idle", {8'h00, req}, 16'h0000);

    irq[0] = 1'b0;
    tick(1);
    check("R3 latency1", {15'd0, req[0]}, 16'd0);
    tick(1);
    check("R3 latency2", {15'd0, req[0]}, 16'd1);

    irq[1] = 1'b0;
    tick(2);
    check("R4 latency2", {15'd0, req[1]}, 16'd0);
    tick(1);
    check("R4 latency3", {15'd0, req[1]}, 16'd1);

    irq[1] = 1'b1;
    tick(4);
    check("R7 sticky", {15'd0, req[1]}, 16'd1);
    pulse_clr(8'h02);
    check("R7 cleared", {15'd0, req[1]}, 16'd0);

    pulse_clr(8'h01);
    check("R7 level ignores clr", {15'd0, req[0]}, 16'd1);
    irq[0] = 1'b1;
    tick(2);
    check("R3 unlatched", {15'd0, req[0]}, 16'd0);

    irq[2] = 1'b1;
    tick(2);
    check("R8 before edge", {15'd0, req[2]}, 16'd0);
    pulse_clr(8'h04);
    check("R8 edge beats clr", {15'd0, req[2]}, 16'd1);

    irq[3] = 1'b0;
    tick(4);
    check("R6 both fall", {15'd0, req[3]}, 16'd1);
    write_mode(16'h0064);
    check("R9 mode change clears", {15'd0, req[3]}, 16'd0);
    check("R9 others kept", {15'd0, req[2]}, 16'd1);
    tick(4);
    check("R9 no false edge", {15'd0, req[3]}, 16'd0);

    finish_run();
  end
endmodule